// File: doc/BRIEF.md
# Input Capture Unit with Noise Filter

This block timestamps transitions on an external pin. The asynchronous pin first passes through a two-flop synchronizer. It can then go through a noise filter that changes its output only after several identical samples in a row. The block then picks out either rising or falling transitions. On each selected transition it copies the free-running counter value into a 16-bit capture register and raises a sticky capture flag. Software clears the flag by writing a one.

When the timer uses the capture register as its period limit, the block stops capturing. The register then becomes a plain writable value. The timer that produces the counter and the interrupt logic that consumes the flag belong to other blocks.

Top module: `icu_capture`

## Requirements
- R1: After reset, `cap_o` is 0 and `flag_o` is 0.
- R2: With the filter off, the synchronizer adds a fixed latency. A pin change set up before clock edge n is captured at edge n+2, and `cap_o` then holds the `count_i` value sampled at that edge. A one-cycle pulse is enough to trigger a capture.
- R3: With `edge_rise_i` = 1, only a 0-to-1 transition of the pin triggers a capture. A 1-to-0 transition leaves `cap_o` and `flag_o` unchanged.
- R4: With `edge_rise_i` = 0, only a 1-to-0 transition triggers a capture. A 0-to-1 transition leaves `cap_o` and `flag_o` unchanged.
- R5: With `filt_en_i` = 1, the filtered level takes a new value only after four consecutive synchronized samples agree on it. A pulse shorter than four cycles causes no capture.
- R6: With the filter on, a capture happens exactly four cycles later than it would with the filter off. That is edge n+6, and it stores `count_i` as sampled at that edge.
- R7: A capture sets `flag_o` at the same edge that loads `cap_o`. `flag_clr_i` = 1 clears `flag_o` at the next edge. If a capture and a clear fall on the same edge, the capture wins.
- R8: While `top_mode_i` = 1, pin transitions change neither `cap_o` nor `flag_o`.
- R9: While `top_mode_i` = 1, `wr_en_i` = 1 loads `wr_data_i` into `cap_o` at the next edge. While `top_mode_i` = 0, `wr_en_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw, unsynchronized capture pin |
| filt_en_i | input | 1 | 1 enables the four-sample noise filter |
| edge_rise_i | input | 1 | 1 selects rising edges, 0 selects falling edges |
| top_mode_i | input | 1 | 1 when the timer uses the capture register as its period limit |
| count_i | input | 16 | Timer counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| flag_clr_i | input | 1 | Write-one clear of the capture flag |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Capture flag |

## Verification
The checker assumes that `filt_en_i` and `edge_rise_i` change only while the pin has been steady for at least four cycles. Switching the filtered level source in the middle of a transition could otherwise produce an edge that no stimulus asked for. The stimulus changes these controls only between events, and it leaves at least twelve idle cycles after each pin change. It also never asserts a flag clear in the same cycle as an expected capture, so every capture shows up at the ports as a separate flag rise.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[0] <= 1'b0;
        else         ff_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic en_i,
  output logic q_o
);
  localparam int HistW = LEN - 1;

  logic [HistW-1:0] hist_q;
  logic [LEN-1:0]   win;
  logic             filt_q;

  // current sample plus LEN-1 previous ones
  assign win = {hist_q, d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= win[HistW-1:0];
      if (&win)       filt_q <= 1'b1;
      else if (~|win) filt_q <= 1'b0;
    end
  end

  assign q_o = en_i ? filt_q : d_i;
endmodule

// File: rtl/icu_edge.sv
module icu_edge
  import icu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic rise_i,
  output logic stb_o
);
  logic      prev_q;
  edge_sel_e sel;

  assign sel = edge_sel_e'(rise_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;

  always_comb begin
    unique case (sel)
      EDGE_RISE: stb_o = level_i & ~prev_q;
      default:   stb_o = ~level_i & prev_q;
    endcase
  end
endmodule

// File: rtl/icu_capture.sv
module icu_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             top_mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  logic pin_sync;
  logic level;
  logic cap_stb;
  logic do_cap;
  logic do_wr;

  icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  icu_filter #(.LEN(FILT_LEN)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_sync),
    .en_i  (filt_en_i),
    .q_o   (level)
  );

  icu_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level),
    .rise_i (edge_rise_i),
    .stb_o  (cap_stb)
  );

  // register acts as period limit in top mode: no capture, writable
  assign do_cap = cap_stb & ~top_mode_i;
  assign do_wr  = wr_en_i & top_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (do_wr)       cap_o <= wr_data_i;
      else if (do_cap) cap_o <= count_i;
      if (do_cap)          flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/icu_capture_chk.sv
module icu_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             top_mode_i,
  input logic [CNT_W-1:0] count_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             flag_clr_i,
  input logic             cap_stb_i,
  input logic [CNT_W-1:0] cap_o,
  input logic             flag_o
);
  // R2
  capture_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_stb_i && !top_mode_i) |=> (cap_o == $past(count_i)));

  // R7
  capture_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_stb_i && !top_mode_i) |=> flag_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(cap_stb_i && !top_mode_i)) |=> !flag_o);

  // R8
  top_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> !$past(top_mode_i));

  // R8
  top_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_mode_i && !wr_en_i) |=> $stable(cap_o));

  // R9
  top_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_mode_i && wr_en_i) |=> (cap_o == $past(wr_data_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!top_mode_i && !cap_stb_i) |=> $stable(cap_o));
endmodule

bind icu_capture icu_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .top_mode_i(top_mode_i),
  .count_i   (count_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .flag_clr_i(flag_clr_i),
  .cap_stb_i (cap_stb),
  .cap_o     (cap_o),
  .flag_o    (flag_o)
);

// File: tb/tb_icu_capture.sv
module tb_icu_capture;
  typedef struct {
    logic [15:0] val;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0;
  logic        filt_en_i = 1'b0;
  logic        edge_rise_i = 1'b1;
  logic        top_mode_i = 1'b0;
  logic [15:0] count_i = 16'h0100;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        flag_clr_i = 1'b0;
  logic [15:0] cap_o;
  logic        flag_o;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) count_i <= count_i + 16'd1;

  icu_capture dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .filt_en_i  (filt_en_i),
    .edge_rise_i(edge_rise_i),
    .top_mode_i (top_mode_i),
    .count_i    (count_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .flag_clr_i (flag_clr_i),
    .cap_o      (cap_o),
    .flag_o     (flag_o)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  // driver: change pin level, push expectation if a capture is due
  task automatic drive_pin(input logic lvl, input bit expect_cap, input string req);
    @(negedge clk_i);
    if (expect_cap) exp_q.push_back('{count_i + (filt_en_i ? 16'd6 : 16'd2), req});
    pin_i = lvl;
    repeat (12) @(negedge clk_i);
  endtask

  task automatic pulse_pin(input int width, input bit expect_cap, input string req);
    @(negedge clk_i);
    if (expect_cap) exp_q.push_back('{count_i + 16'd2, req});
    pin_i = 1'b1;
    repeat (width) @(negedge clk_i);
    pin_i = 1'b0;
    repeat (12) @(negedge clk_i);
  endtask

  // monitor: pop on each flag rise, then clear the flag (R7)
  initial begin
    forever begin
      @(negedge clk_i);
      if (flag_clr_i) begin
        flag_clr_i = 1'b0;
        check("R7 flag cleared", {16'h0, flag_o}, 17'h0);
      end else if (flag_o) begin
        if (exp_q.size() == 0) begin
          check("R3/R4/R5/R8 unexpected capture", {cap_o, flag_o}, {cap_o, 1'b0});
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, {cap_o, flag_o}, {e.val, 1'b1});
        end
        flag_clr_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    check("watchdog", 17'h1, 17'h0);
    finish_run();
  end

  initial begin
    logic [15:0] last;
    repeat (3) @(negedge clk_i);
    check("R1 reset cap/flag", {cap_o, flag_o}, 17'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 after release", {cap_o, flag_o}, 17'h0);

    // R2 R3: rising select, no filter
    drive_pin(1'b1, 1, "R2 R3 rising capture");
    last = cap_o;
    drive_pin(1'b0, 0, "R3");
    check("R3 falling ignored", {cap_o, flag_o}, {last, 1'b0});
    pulse_pin(1, 1, "R2 one-cycle pulse");

    // R4: falling select
    edge_rise_i = 1'b0;
    drive_pin(1'b1, 0, "R4");
    check("R4 rising ignored", {16'h0, flag_o}, 17'h0);
    drive_pin(1'b0, 1, "R4 falling capture");

    // R5 R6: filter enabled
    edge_rise_i = 1'b1;
    filt_en_i = 1'b1;
    repeat (6) @(negedge clk_i);
    drive_pin(1'b1, 1, "R6 filtered latency");
    drive_pin(1'b0, 0, "R5");
    last = cap_o;
    pulse_pin(3, 0, "R5");
    check("R5 short pulse rejected", {cap_o, flag_o}, {last, 1'b0});
    filt_en_i = 1'b0;
    repeat (6) @(negedge clk_i);
    pulse_pin(3, 1, "R5 unfiltered short pulse captured");

    // R9: write outside top mode ignored
    last = cap_o;
    wr_data_i = 16'hBEEF;
    wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check("R9 write ignored outside top mode", {16'h0, cap_o}, {16'h0, last});

    // R9 R8: top mode
    top_mode_i = 1'b1;
    wr_data_i = 16'h1234;
    wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R9 top-mode write", {16'h0, cap_o}, {16'h0, 16'h1234});
    drive_pin(1'b1, 0, "R8");
    drive_pin(1'b0, 0, "R8");
    check("R8 edges ignored in top mode", {cap_o, flag_o}, {16'h1234, 1'b0});
    top_mode_i = 1'b0;
    repeat (4) @(negedge clk_i);
    drive_pin(1'b1, 1, "R8 capture resumes");

    repeat (4) @(negedge clk_i);
    check("R2 all expected captures seen", {16'h0, 1'b0} | 17'(exp_q.size()), 17'h0);
    finish_run();
  end
endmodule